// File: doc/BRIEF.md
# Pattern-Sweep Self-Test Controller

This block runs a self-test on a small combinational circuit that has three inputs and five outputs. The circuit is outside the block. The block drives the circuit's inputs through `cut_in` and reads its outputs back on `cut_out`. When `test_mode` is low, the circuit sees the functional inputs unchanged. When `test_mode` is high and `start` is pulsed, a three-bit pseudo-random generator sweeps all eight input combinations, one per clock.

For every combination, a golden lookup table addressed by that same combination gives the five-bit response the circuit should produce. The applied pattern and the observed response are registered together. On the following cycle they are compared. A mismatch on any output bit sets a sticky fail flag. This detects any single output stuck at 0 or at 1. A one-cycle `done` pulse ends a completed sweep.

Top module: `bist_sweep_top`

## Requirements
- R1: While reset is asserted and right after it, `done` and `fail` are both 0.
- R2: With `test_mode` low, `cut_in` equals `func_in` in the same cycle. With `test_mode` high, `cut_in` carries the generator pattern.
- R3: After `start` is sampled high in test mode, `cut_in` shows the following patterns, one per cycle from the next cycle onward: 3'b001, 3'b010, 3'b101, 3'b011, 3'b111, 3'b110, 3'b100, 3'b000. These are written {a,b,c} with a at bit 2. The first seven come from the feedback polynomial x^3+x^2+1.
- R4: For a fault-free circuit, `done` is high in exactly the ninth cycle after the clock edge that samples `start`, and `fail` is 0 in that cycle.
- R5: When any one of the five outputs is stuck at 0 or at 1, `fail` is 1 by the cycle in which `done` is high.
- R6: Once `fail` is 1 it stays 1 until reset, including through later sweeps of a fault-free circuit.
- R7: A `start` pulse during a sweep is ignored. The pattern order and the timing of `done` are unchanged.
- R8: Lowering `test_mode` during a sweep aborts it. `done` is not raised for that sweep, and a later `start` runs a full sweep.
- R9: A `start` pulse while `test_mode` is low does not begin a sweep, and `done` stays 0.
- R10: `done` is high for a single cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| test_mode | input | 1 | Selects test patterns for the circuit and enables sweeps |
| start | input | 1 | Begins a sweep when idle and in test mode |
| func_in | input | 3 | Functional input vector for the circuit |
| cut_in | output | 3 | Vector applied to the circuit under test |
| cut_out | input | 5 | Response observed from the circuit under test |
| done | output | 1 | One-cycle pulse at the end of a completed sweep |
| fail | output | 1 | Sticky mismatch flag |

## Verification
The compare of the final pattern and the `done` pulse update on the same clock edge. A mismatch that appears late in the sweep must therefore be visible in `fail` in exactly the cycle where `done` rises. The bench runs sweeps with each output stuck at each value and reads `fail` in the `done` cycle. In a second pair of coincidences, a `start` pulse arrives while the pattern counter is advancing, and `test_mode` falls while compares are still in flight. The scoreboard must see the pattern order unchanged in the first case and no `done` at all in the second.

// File: rtl/bist_pkg.sv
package bist_pkg;
    localparam int PAT_W = 3;
    localparam int RSP_W = 5;
    localparam int NVEC  = 1 << PAT_W;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sweep_st_e;

    // Golden response: pattern bit 2 is a, bit 1 is b, bit 0 is c.
    function automatic logic [RSP_W-1:0] golden_resp(input logic [PAT_W-1:0] v);
        logic a, b, c;
        logic [RSP_W-1:0] r;
        a = v[2];
        b = v[1];
        c = v[0];
        r[0] = (a & ~b & c) ^ (~a & b);
        r[1] = (~a & ~b & c) ^ (a & c);
        r[2] = (a & ~b & c) ^ (b & ~c) ^ (~a & b);
        r[3] = a & c;
        r[4] = (b & ~c) ^ (~a & b) ^ (a & c);
        return r;
    endfunction
endpackage

// File: rtl/sweep_lfsr.sv
module sweep_lfsr #(
    parameter int          W    = bist_pkg::PAT_W,
    parameter logic [W-1:0] TAPS = 3'b110,
    parameter logic [W-1:0] SEED = 3'b001
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         adv,
    input  logic         to_zero,
    output logic [W-1:0] pat
);
    logic [W-1:0] pat_d, pat_q;
    logic         fb;

    always_comb begin
        fb    = ^(pat_q & TAPS);
        pat_d = pat_q;
        if (load) begin
            pat_d = SEED;
        end else if (adv) begin
            if (to_zero) pat_d = '0;
            else         pat_d = {pat_q[W-2:0], fb};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pat_q <= SEED;
        else        pat_q <= pat_d;
    end

    assign pat = pat_q;

    // R3: a freshly loaded generator never sits in the lock-up state
    a_r3_seed_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load) |-> (pat_q != '0));
endmodule

// File: rtl/golden_rom.sv
module golden_rom #(
    parameter int AW = bist_pkg::PAT_W,
    parameter int DW = bist_pkg::RSP_W
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] tbl [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign tbl[i] = bist_pkg::golden_resp(AW'(i));
    end

    assign data = tbl[addr];
endmodule

// File: rtl/resp_cmp.sv
module resp_cmp #(
    parameter int DW = bist_pkg::RSP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_en,
    input  logic          smp_last,
    input  logic          keep,
    input  logic [DW-1:0] exp_rsp,
    input  logic [DW-1:0] obs_rsp,
    output logic          done,
    output logic          fail
);
    typedef struct packed {
        logic          vld;
        logic          last;
        logic [DW-1:0] exp;
        logic [DW-1:0] obs;
        logic          done;
        logic          fail;
    } cmp_t;

    cmp_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.vld  = smp_en;
        s_d.last = smp_en & smp_last;
        s_d.exp  = exp_rsp;
        s_d.obs  = obs_rsp;
        s_d.fail = s_q.fail | (s_q.vld & (s_q.exp != s_q.obs));
        s_d.done = s_q.vld & s_q.last & keep;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done = s_q.done;
    assign fail = s_q.fail;

    a_r6_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> fail);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/bist_sweep_top.sv
module bist_sweep_top #(
    parameter int PAT_W = bist_pkg::PAT_W,
    parameter int RSP_W = bist_pkg::RSP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_mode,
    input  logic             start,
    input  logic [PAT_W-1:0] func_in,
    output logic [PAT_W-1:0] cut_in,
    input  logic [RSP_W-1:0] cut_out,
    output logic             done,
    output logic             fail
);
    import bist_pkg::*;

    localparam int NV    = 1 << PAT_W;
    localparam int CNT_W = PAT_W;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NV - 1);
    localparam logic [CNT_W-1:0] ZERO_IDX = CNT_W'(NV - 2);

    typedef struct packed {
        sweep_st_e        st;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t c_d, c_q;

    logic             go, running, load, adv, to_zero, smp_en, smp_last;
    logic [PAT_W-1:0] pat;
    logic [RSP_W-1:0] exp_rsp;

    always_comb begin
        running  = (c_q.st == ST_RUN);
        go       = (c_q.st == ST_IDLE) && start && test_mode;
        load     = go;
        adv      = running && test_mode && (c_q.cnt != LAST_IDX);
        to_zero  = (c_q.cnt == ZERO_IDX);
        smp_en   = running && test_mode;
        smp_last = (c_q.cnt == LAST_IDX);

        c_d = c_q;
        unique case (c_q.st)
            ST_IDLE: begin
                if (go) begin
                    c_d.st  = ST_RUN;
                    c_d.cnt = '0;
                end
            end
            ST_RUN: begin
                if (!test_mode || (c_q.cnt == LAST_IDX)) begin
                    c_d.st = ST_IDLE;
                end else begin
                    c_d.cnt = c_q.cnt + 1'b1;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st  <= ST_IDLE;
            c_q.cnt <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    sweep_lfsr #(.W(PAT_W)) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .adv     (adv),
        .to_zero (to_zero),
        .pat     (pat)
    );

    assign cut_in = test_mode ? pat : func_in;

    golden_rom #(.AW(PAT_W), .DW(RSP_W)) u_rom (
        .addr (pat),
        .data (exp_rsp)
    );

    resp_cmp #(.DW(RSP_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_en   (smp_en),
        .smp_last (smp_last),
        .keep     (test_mode),
        .exp_rsp  (exp_rsp),
        .obs_rsp  (cut_out),
        .done     (done),
        .fail     (fail)
    );

    // R7: a start seen mid-sweep leaves the vector counter advancing by one
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (running && start && test_mode && (c_q.cnt != LAST_IDX))
        |=> (c_q.cnt == $past(c_q.cnt) + 1'b1) && (c_q.st == ST_RUN));

    // R8: no completion pulse follows a cycle spent outside test mode
    a_r8_abort_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |=> !done);

    // R9: a start outside test mode leaves the controller idle
    a_r9_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.st == ST_IDLE) && !test_mode) |=> (c_q.st == ST_IDLE));
endmodule

// File: tb/cut_model.sv
module cut_model (
    input  logic [2:0] x,
    input  logic       flt_en,
    input  logic [2:0] flt_bit,
    input  logic       flt_val,
    output logic [4:0] y
);
    logic [4:0] good;
    logic a, b, c;

    always_comb begin
        a = x[2];
        b = x[1];
        c = x[0];
        good[0] = (a && !b && c) != (!a && b);
        good[1] = (!a && !b && c) != (a && c);
        good[2] = ((a && !b && c) != (b && !c)) != (!a && b);
        good[3] = a && c;
        good[4] = ((b && !c) != (!a && b)) != (a && c);
        y = good;
        if (flt_en) y[flt_bit] = flt_val;
    end
endmodule

// File: tb/bist_sweep_top_test.sv
module bist_sweep_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       test_mode = 1'b0;
    logic       start = 1'b0;
    logic [2:0] func_in = 3'd0;
    logic [2:0] cut_in;
    logic [4:0] cut_out;
    logic       done, fail;
    logic       flt_en = 1'b0;
    logic [2:0] flt_bit = 3'd0;
    logic       flt_val = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    logic [2:0] exp_pat_q[$];

    always #10 clk = ~clk;

    bist_sweep_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_mode (test_mode),
        .start     (start),
        .func_in   (func_in),
        .cut_in    (cut_in),
        .cut_out   (cut_out),
        .done      (done),
        .fail      (fail)
    );

    cut_model u_cut (
        .x       (cut_in),
        .flt_en  (flt_en),
        .flt_bit (flt_bit),
        .flt_val (flt_val),
        .y       (cut_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops one expected pattern per cycle, sampled after the falling edge
    always @(negedge clk) begin
        logic [2:0] e;
        #2;
        if (exp_pat_q.size() > 0) begin
            e = exp_pat_q.pop_front();
            chk(cut_in == e, "R3 pattern order", cut_in, e);
        end
    end

    task automatic push_sweep();
        exp_pat_q.push_back(3'b001);
        exp_pat_q.push_back(3'b010);
        exp_pat_q.push_back(3'b101);
        exp_pat_q.push_back(3'b011);
        exp_pat_q.push_back(3'b111);
        exp_pat_q.push_back(3'b110);
        exp_pat_q.push_back(3'b100);
        exp_pat_q.push_back(3'b000);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R1 done in reset", done, 0);
        chk(fail == 1'b0, "R1 fail in reset", fail, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && fail == 1'b0, "R1 after reset", {done, fail}, 0);
    endtask

    // Full sweep; poke>0 raises start again at that cycle (R7)
    task automatic run_sweep(input bit exp_fail, input int poke, input string tag);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        push_sweep();
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            start = (i == poke);
            chk(done == 1'b0, {tag, " R4 no early done"}, done, 0);
        end
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, {tag, " R4 done at ninth cycle"}, done, 1);
        chk(fail == exp_fail, {tag, " R5 fail at done"}, fail, exp_fail);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R10 done single cycle"}, done, 0);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();

        // R2: functional path
        test_mode = 1'b0;
        for (int v = 0; v < 8; v += 3) begin
            @(negedge clk);
            func_in = 3'(v);
            #1;
            chk(cut_in == 3'(v), "R2 functional mux", cut_in, v);
        end

        // R9: start ignored outside test mode
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk(done == 1'b0, "R9 no sweep outside test mode", done, 0);
        end

        // R3/R4/R10: fault-free sweep
        test_mode = 1'b1;
        run_sweep(1'b0, 0, "clean");

        // R7: start during sweep
        run_sweep(1'b0, 3, "restart-poke");

        // R8: abort mid-sweep
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        test_mode = 1'b0;
        func_in = 3'b110;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk(done == 1'b0, "R8 no done after abort", done, 0);
        end
        chk(cut_in == 3'b110, "R8 R2 functional after abort", cut_in, 6);
        test_mode = 1'b1;
        run_sweep(1'b0, 0, "after-abort R8");

        // R5: every output stuck at each value
        for (int b = 0; b < 5; b++) begin
            for (int v = 0; v < 2; v++) begin
                flt_en  = 1'b0;
                do_reset();
                flt_en  = 1'b1;
                flt_bit = 3'(b);
                flt_val = v[0];
                run_sweep(1'b1, 0, "stuck R5");
            end
        end

        // R6: fail survives a clean sweep
        flt_en = 1'b0;
        run_sweep(1'b1, 0, "sticky R6");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule